// File: doc/BRIEF.md
# Pipeline Data Hazard Interlock

This block holds back an in-order, single-issue, five-stage integer pipeline when an instruction in the decode stage needs a register value that an older instruction has not yet written. The five stages are fetch, decode with register read, execute, memory and write-back. There are no bypass paths. A result becomes usable only when its producer sits in write-back. The register file stores in the early part of a cycle and supplies operands in the late part, so a producer in write-back does not hold up a reader in decode. Each slot carries a valid bit, a destination field, a flag for whether it writes a register, two source fields with a use flag for each, and an identifying tag.

Each source field in decode is compared on its own against the destinations of the valid, register-writing instructions in execute and memory. Register zero never counts. When any comparison hits, the stall output rises. Fetch and decode then keep their contents and no new instruction is taken from the input. The execute stage receives an empty slot, and the older instructions keep moving. As a result, a consumer right behind its producer waits two cycles, one instruction further back waits one cycle, and three or more back waits none. Around the detector the block contains a small model of the stage registers. The surrounding logic offers one fetch slot per cycle and keeps it on the inputs while stall is high.

Top module: `hazard_interlock`

## Requirements
- R1: While reset is high and on the first cycle after it, every stage is empty: id_valid, ex_valid and wb_valid are 0 and stall is 0.
- R2: An instruction whose used source names the destination of the valid, register-writing instruction directly ahead of it is held in decode for exactly two stall cycles.
- R3: When the matching producer is two instructions ahead, with an unrelated instruction between them, the consumer is held for exactly one stall cycle.
- R4: When the matching producer is three or more instructions ahead, the consumer has no stall cycle. A producer in write-back satisfies a reader in decode in the same cycle.
- R5: A source or destination field equal to 0 (register zero) never creates a dependency.
- R6: A producer whose register-write flag is 0 (such as a store, branch or jump) never causes a stall.
- R7: The two source fields are compared independently. A match on the second field alone stalls just as a match on the first field does. A field whose use flag is 0 is ignored even if it matches.
- R8: While stall is high, the fetch and decode contents are held and the input is not consumed. Every valid instruction offered reaches write-back exactly once, in offer order, with its own tag.
- R9: Each cycle with stall high is followed by a cycle in which the execute stage is empty (ex_valid = 0).
- R10: An empty slot (valid bit 0) is never a producer and never stalls when it sits in decode, whatever its fields hold.
- R11: Over a long random instruction stream, the stall cycles of each instruction equal a reference timing model: the decode exit cycle is the later of its arrival and three cycles after the decode exit of its latest matching producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offered fetch slot holds an instruction |
| in_src_a | input | 5 | First source register field |
| in_use_a | input | 1 | First source field is read |
| in_src_b | input | 5 | Second source register field |
| in_use_b | input | 1 | Second source field is read |
| in_dst | input | 5 | Destination register field |
| in_wr | input | 1 | Instruction writes its destination in write-back |
| in_tag | input | 8 | Identifier carried alongside the instruction |
| stall | output | 1 | Fetch and decode hold; a bubble enters execute |
| id_valid | output | 1 | Decode stage holds an instruction |
| id_tag | output | 8 | Tag of the decode-stage instruction |
| ex_valid | output | 1 | Execute stage holds an instruction |
| wb_valid | output | 1 | Write-back stage holds an instruction |
| wb_tag | output | 8 | Tag of the write-back instruction |
| wb_dst | output | 5 | Destination field in write-back |
| wb_wr | output | 1 | Write flag in write-back |

## Verification
Directed pairs place a producer at distances one, two and three from its consumer. These separate the two-cycle, one-cycle and zero-cycle outcomes, which shows whether both execute and memory are compared and whether write-back is correctly left out. Further pairs use a register-zero destination, a producer that does not write, an empty slot with a matching destination, a match on the second source only and a match on a source whose use flag is 0. Each of these isolates one qualifier of the comparison. A long random stream over eight registers, with random use flags, write flags and empty slots, checks each instruction's stall count against the timing model, and its retirement order and tag. This catches any hold or bubble fault that loses, duplicates or reorders an instruction.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int RA_W     = 5;
    localparam int TAG_W    = 8;
    localparam int N_SRC    = 2;

    localparam int STG_IF   = 0;
    localparam int STG_ID   = 1;
    localparam int STG_EX   = 2;
    localparam int STG_MEM  = 3;
    localparam int STG_WB   = 4;
    localparam int N_STAGES = 5;
    localparam int N_AHEAD  = STG_WB - STG_EX;

    typedef logic [RA_W-1:0]  raddr_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic                   valid;
        logic                   wr;
        raddr_t                 dst;
        logic [N_SRC-1:0]       use_src;
        raddr_t [N_SRC-1:0]     src;
        tag_t                   tag;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '0;

    function automatic logic produces(slot_t s);
        return s.valid && s.wr && (s.dst != '0);
    endfunction

endpackage

// File: rtl/ilk_src_cmp.sv
module ilk_src_cmp
    import ilk_pkg::*;
(
    input  raddr_t                  src,
    input  logic                    src_en,
    input  slot_t [N_AHEAD-1:0]     ahead,
    output logic                    hit
);

    logic [N_AHEAD-1:0] match;

    for (genvar k = 0; k < N_AHEAD; k++) begin : g_ahead
        assign match[k] = produces(ahead[k]) && (ahead[k].dst == src);
    end

    assign hit = src_en && (src != '0) && (|match);

endmodule

// File: rtl/ilk_hazard_unit.sv
module ilk_hazard_unit
    import ilk_pkg::*;
(
    input  slot_t                   dec,
    input  slot_t [N_AHEAD-1:0]     ahead,
    output logic                    stall
);

    logic [N_SRC-1:0] src_hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        ilk_src_cmp u_cmp (
            .src    (dec.src[g]),
            .src_en (dec.valid && dec.use_src[g]),
            .ahead  (ahead),
            .hit    (src_hit[g])
        );
    end

    assign stall = |src_hit;

endmodule

// File: rtl/ilk_pipe_regs.sv
module ilk_pipe_regs
    import ilk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  slot_t   fetch_in,
    output slot_t   stg_q [N_STAGES]
);

    // Stages up to decode freeze on hold; execute takes a bubble; later stages drain.
    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        if (k == STG_IF) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)        stg_q[k] <= EMPTY_SLOT;
                else if (!hold) stg_q[k] <= fetch_in;
            end
        end else if (k <= STG_ID) begin : g_held
            always_ff @(posedge clk) begin
                if (rst)        stg_q[k] <= EMPTY_SLOT;
                else if (!hold) stg_q[k] <= stg_q[k-1];
            end
        end else if (k == STG_EX) begin : g_bubble
            always_ff @(posedge clk) begin
                if (rst)       stg_q[k] <= EMPTY_SLOT;
                else if (hold) stg_q[k] <= EMPTY_SLOT;
                else           stg_q[k] <= stg_q[k-1];
            end
        end else begin : g_flow
            always_ff @(posedge clk) begin
                if (rst) stg_q[k] <= EMPTY_SLOT;
                else     stg_q[k] <= stg_q[k-1];
            end
        end
    end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import ilk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [RA_W-1:0]     in_src_a,
    input  logic                in_use_a,
    input  logic [RA_W-1:0]     in_src_b,
    input  logic                in_use_b,
    input  logic [RA_W-1:0]     in_dst,
    input  logic                in_wr,
    input  logic [TAG_W-1:0]    in_tag,
    output logic                stall,
    output logic                id_valid,
    output logic [TAG_W-1:0]    id_tag,
    output logic                ex_valid,
    output logic                wb_valid,
    output logic [TAG_W-1:0]    wb_tag,
    output logic [RA_W-1:0]     wb_dst,
    output logic                wb_wr
);

    slot_t                  fetch_in;
    slot_t                  stg [N_STAGES];
    slot_t                  id_q;
    slot_t [N_AHEAD-1:0]    ahead;

    always_comb begin
        fetch_in            = EMPTY_SLOT;
        fetch_in.valid      = in_valid;
        fetch_in.wr         = in_wr;
        fetch_in.dst        = in_dst;
        fetch_in.use_src[0] = in_use_a;
        fetch_in.use_src[1] = in_use_b;
        fetch_in.src[0]     = in_src_a;
        fetch_in.src[1]     = in_src_b;
        fetch_in.tag        = in_tag;
    end

    ilk_pipe_regs u_pipe (
        .clk      (clk),
        .rst      (rst),
        .hold     (stall),
        .fetch_in (fetch_in),
        .stg_q    (stg)
    );

    assign id_q = stg[STG_ID];

    for (genvar k = 0; k < N_AHEAD; k++) begin : g_tap
        assign ahead[k] = stg[STG_EX + k];
    end

    ilk_hazard_unit u_hz (
        .dec   (id_q),
        .ahead (ahead),
        .stall (stall)
    );

    assign id_valid = id_q.valid;
    assign id_tag   = id_q.tag;
    assign ex_valid = stg[STG_EX].valid;
    assign wb_valid = stg[STG_WB].valid;
    assign wb_tag   = stg[STG_WB].tag;
    assign wb_dst   = stg[STG_WB].dst;
    assign wb_wr    = stg[STG_WB].wr;

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker
    import ilk_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  stall,
    input slot_t id_q,
    input logic  ex_valid,
    input logic  wb_valid
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: the cycle right after reset is empty and free of stall
    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            a_r1_empty_after_reset: assert (!ex_valid && !wb_valid && !id_q.valid && !stall);
    end

    // R9: a stall cycle leaves execute empty in the following cycle
    a_r9_bubble: assert property (@(posedge clk) disable iff (rst)
        stall |=> !ex_valid);

    // R8: decode keeps the same instruction across a stall
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> (id_q.valid && $stable(id_q.tag)));

    // R2: no dependency costs more than two consecutive stall cycles
    a_r2_two_max: assert property (@(posedge clk) disable iff (rst)
        (stall && $past(stall)) |=> !stall);

    // R10: an empty decode slot never stalls
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !id_q.valid |-> !stall);

    // R5: sources that are unused or name register zero never stall
    a_r5_zero_src: assert property (@(posedge clk) disable iff (rst)
        ((!id_q.use_src[0] || id_q.src[0] == '0) &&
         (!id_q.use_src[1] || id_q.src[1] == '0)) |-> !stall);

endmodule

bind hazard_interlock ilk_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .id_q     (id_q),
    .ex_valid (ex_valid),
    .wb_valid (wb_valid)
);

// File: tb/sim_hazard_interlock.sv
`timescale 1ns/1ps
module sim_hazard_interlock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [4:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic       in_use_a = 1'b0, in_use_b = 1'b0, in_wr = 1'b0;
    logic [7:0] in_tag = '0;
    logic       stall, id_valid, ex_valid, wb_valid, wb_wr;
    logic [7:0] id_tag, wb_tag;
    logic [4:0] wb_dst;

    always #4 clk = ~clk;

    hazard_interlock u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_src_a(in_src_a), .in_use_a(in_use_a),
        .in_src_b(in_src_b), .in_use_b(in_use_b),
        .in_dst(in_dst), .in_wr(in_wr), .in_tag(in_tag),
        .stall(stall), .id_valid(id_valid), .id_tag(id_tag),
        .ex_valid(ex_valid), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .wb_dst(wb_dst), .wb_wr(wb_wr)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    tag_q[$];
    int    exp_q[$];
    string lbl_q[$];
    int    cnt [256];
    int    rel [32];
    int    e_prev = 0;
    int    tag_ctr = 0;
    bit    done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: reference timing model, then offer the slot until it is taken.
    task automatic issue(input bit v, input int sa, input bit ua, input int sb, input bit ub,
                         input int dst, input bit wr, input string lbl);
        int d, e;
        d = e_prev + 1;
        e = d;
        if (v) begin
            if (ua && sa != 0 && rel[sa] > e) e = rel[sa];
            if (ub && sb != 0 && rel[sb] > e) e = rel[sb];
            tag_q.push_back(tag_ctr);
            exp_q.push_back(e - d);
            lbl_q.push_back(lbl);
            if (wr && dst != 0) rel[dst] = e + 3;
        end
        e_prev = e;
        in_valid = v;
        in_src_a = sa[4:0]; in_use_a = ua;
        in_src_b = sb[4:0]; in_use_b = ub;
        in_dst   = dst[4:0]; in_wr = wr;
        in_tag   = tag_ctr[7:0];
        tag_ctr  = (tag_ctr + 1) % 256;
        while (stall) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) issue(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, "R8");
    endtask

    // Monitor: stall accounting, bubble check, retirement against the queue.
    initial begin
        bit prev_stall;
        int t, x;
        string l;
        prev_stall = 1'b0;
        for (int i = 0; i < 256; i++) cnt[i] = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_stall)
                    check(!ex_valid, "R9 bubble after stall", int'(ex_valid), 0);
                prev_stall = stall;
                if (id_valid && stall) cnt[id_tag]++;
                if (wb_valid) begin
                    if (tag_q.size() == 0) begin
                        check(1'b0, "R8 unexpected retirement", int'(wb_tag), -1);
                    end else begin
                        t = tag_q.pop_front();
                        x = exp_q.pop_front();
                        l = lbl_q.pop_front();
                        check(int'(wb_tag) == t, "R8 retirement order", int'(wb_tag), t);
                        check(cnt[wb_tag] == x, l, cnt[wb_tag], x);
                        cnt[wb_tag] = 0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) rel[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset
        check(!stall && !id_valid && !ex_valid && !wb_valid, "R1 reset state",
              {28'd0, stall, id_valid, ex_valid, wb_valid}, 0);

        // R2: back-to-back dependency, two stall cycles
        issue(1'b1, 0, 1'b0, 0, 1'b0, 3, 1'b1, "R8");
        issue(1'b1, 3, 1'b1, 0, 1'b0, 11, 1'b1, "R2 adjacent dependency");
        gap(3);
        // R7: second field alone, then an unused matching field
        issue(1'b1, 0, 1'b0, 0, 1'b0, 4, 1'b1, "R8");
        issue(1'b1, 9, 1'b1, 4, 1'b1, 12, 1'b1, "R7 second source match");
        gap(3);
        issue(1'b1, 0, 1'b0, 0, 1'b0, 5, 1'b1, "R8");
        issue(1'b1, 5, 1'b0, 5, 1'b0, 13, 1'b1, "R7 unused source ignored");
        gap(3);
        // R3: distance two, one stall cycle
        issue(1'b1, 0, 1'b0, 0, 1'b0, 6, 1'b1, "R8");
        issue(1'b1, 0, 1'b0, 0, 1'b0, 20, 1'b1, "R8");
        issue(1'b1, 6, 1'b1, 0, 1'b0, 14, 1'b1, "R3 distance two");
        gap(3);
        // R4: distance three, none
        issue(1'b1, 0, 1'b0, 0, 1'b0, 7, 1'b1, "R8");
        issue(1'b1, 0, 1'b0, 0, 1'b0, 21, 1'b1, "R8");
        issue(1'b1, 0, 1'b0, 0, 1'b0, 22, 1'b1, "R8");
        issue(1'b1, 7, 1'b1, 7, 1'b1, 15, 1'b1, "R4 distance three");
        gap(3);
        // R5: register zero
        issue(1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b1, "R8");
        issue(1'b1, 0, 1'b1, 0, 1'b1, 16, 1'b1, "R5 register zero");
        gap(3);
        // R6: non-writing producer
        issue(1'b1, 0, 1'b0, 0, 1'b0, 8, 1'b0, "R8");
        issue(1'b1, 8, 1'b1, 0, 1'b0, 17, 1'b1, "R6 non-writing producer");
        gap(3);
        // R10: empty slot with a matching destination
        issue(1'b0, 0, 1'b0, 0, 1'b0, 10, 1'b1, "R10");
        issue(1'b1, 0, 1'b0, 10, 1'b1, 18, 1'b1, "R10 empty slot not a producer");
        gap(3);
        // R11: random stream
        for (int i = 0; i < 400; i++) begin
            issue(($urandom % 8) != 0, $urandom % 8, $urandom % 2, $urandom % 8,
                  $urandom % 2, $urandom % 8, $urandom % 2, "R11 random stream");
        end
        gap(8);
        check(tag_q.size() == 0, "R8 all instructions retired", tag_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule